// File: doc/BRIEF.md
# Multi-buffer packet commit FIFO

This block passes bytes from a packet producer, such as the receive side of a bulk-OUT endpoint, to a streaming consumer port. Its storage is a ring of `BUF_COUNT` equal buffers of `BUF_BYTES` bytes each. The producer fills one buffer at a time. A buffer is handed to the consumer side (committed) when its last slot is written, or earlier when the producer marks a byte as the end of a short packet. The next byte after a commit always opens the next buffer in the ring. Each committed buffer remembers how many bytes it holds. The consumer reads committed buffers strictly in commit order and sees an end-of-buffer marker on the last valid byte of each one.

When every buffer is committed and not yet fully read, the producer is refused with a registered NAK-style flag, and bytes it offers are dropped. A buffer returns to the free pool only when its final byte has been read. With more than one buffer, the producer and the consumer run in the same cycles. A 2-bit thread address selects which of four threads' empty flags is reported. Only thread 0 has storage behind it; the other three always report empty.

The producer control is a state machine with states OPEN (no partial buffer), FILL (a buffer is partly written) and FULL (every buffer committed). Its transitions are OPEN→FILL on a byte that does not commit, FILL→OPEN on a commit, OPEN/FILL→FULL when a commit takes the last free buffer, and FULL→OPEN when a buffer is released. The consumer control has IDLE (nothing committed) and DRAIN (at least one committed buffer). It moves IDLE→DRAIN on the first commit and DRAIN→IDLE when the last committed buffer is released.

Top module: `mbf_commit_fifo`

## Requirements
- R1: A synchronous active-high reset, applied at any time, empties every buffer. After it, cons_valid=0, prod_nak=0 and thr_empty=1 for thr_addr=0.
- R2: Bytes accepted from the producer (prod_valid=1 while prod_nak=0) appear on cons_data unchanged and in acceptance order.
- R3: Writing the last slot of a buffer (its BUF_BYTES-th byte) commits it without prod_last. cons_valid is 1 from the cycle after the accepting edge.
- R4: A byte with prod_last=1 commits the current buffer with its byte count, and the next byte starts a new buffer. cons_eob=1 exactly on the last valid byte of each committed buffer.
- R5: Committed buffers are delivered whole and in the order they were committed.
- R6: prod_nak is 1 exactly when all BUF_COUNT buffers are committed and not yet released. Bytes offered while it is 1 are not stored and never reach the consumer.
- R7: A buffer is released by the transfer of its cons_eob byte. prod_nak falls in the cycle after that edge.
- R8: For thr_addr=0, thr_empty is 1 exactly when no committed, unreleased buffer exists. For thr_addr 1, 2 and 3, thr_empty is always 1.
- R9: With BUF_COUNT>1, a byte can be accepted from the producer in the same cycle as a byte is transferred to the consumer.
- R10: While cons_valid=1 and cons_ready=0, cons_valid, cons_data and cons_eob stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prod_valid | input | 1 | Producer offers a byte |
| prod_data | input | DATA_W | Producer byte |
| prod_last | input | 1 | Offered byte ends a short packet |
| prod_nak | output | 1 | Registered refusal, no free buffer |
| cons_ready | input | 1 | Consumer takes the presented byte |
| cons_valid | output | 1 | A committed byte is presented |
| cons_data | output | DATA_W | Presented byte |
| cons_eob | output | 1 | Presented byte is the last of its buffer |
| thr_addr | input | THR_W | Thread whose flag is reported |
| thr_empty | output | 1 | Empty flag of the selected thread |

## Verification
A byte accepted at a clock edge that commits a buffer makes cons_valid and the thread-0 empty flag change right after that edge. A release edge drops prod_nak right after that edge. cons_data and cons_eob follow the read pointer with no added register, and thr_empty follows thr_addr with no delay. The bench drives inputs at the falling edge and checks all outputs one time unit after the next falling edge, against a byte-queue model in the bench that is updated at the rising edge between the two. Packet lengths are swept from one byte to past two buffers, and a mixed phase cycles through all four thread addresses while both sides run.

// File: rtl/mbf_pkg.sv
package mbf_pkg;
    typedef enum logic [1:0] {
        P_OPEN = 2'd0,
        P_FILL = 2'd1,
        P_FULL = 2'd2
    } prod_state_e;

    typedef enum logic {
        C_IDLE  = 1'b0,
        C_DRAIN = 1'b1
    } cons_state_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/mbf_store.sv
module mbf_store import mbf_pkg::*; #(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned BUF_BYTES = 16,
    parameter int unsigned BUF_COUNT = 4,
    localparam int unsigned IDX_W = idx_width(BUF_COUNT),
    localparam int unsigned OFF_W = idx_width(BUF_BYTES),
    localparam int unsigned LEN_W = $clog2(BUF_BYTES + 1)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_buf,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_val,
    input  logic [IDX_W-1:0]  rd_buf,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    output logic [LEN_W-1:0]  rd_len
);
    localparam int unsigned DEPTH  = BUF_COUNT * BUF_BYTES;
    localparam int unsigned ADDR_W = idx_width(DEPTH);

    logic [DATA_W-1:0] mem   [DEPTH];
    logic [LEN_W-1:0]  len_q [BUF_COUNT];
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;

    // flat address = buffer index * buffer size + offset
    assign wr_addr = ADDR_W'(wr_buf) * ADDR_W'(BUF_BYTES) + ADDR_W'(wr_off);
    assign rd_addr = ADDR_W'(rd_buf) * ADDR_W'(BUF_BYTES) + ADDR_W'(rd_off);

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // byte count recorded when a buffer is committed
    always_ff @(posedge clk) begin
        if (len_we) begin
            len_q[wr_buf] <= len_val;
        end
    end

    assign rd_data = mem[rd_addr];
    assign rd_len  = len_q[rd_buf];
endmodule

// File: rtl/mbf_prod_ctl.sv
module mbf_prod_ctl import mbf_pkg::*; #(
    parameter int unsigned BUF_BYTES = 16,
    parameter int unsigned BUF_COUNT = 4,
    localparam int unsigned IDX_W = idx_width(BUF_COUNT),
    localparam int unsigned OFF_W = idx_width(BUF_BYTES),
    localparam int unsigned LEN_W = $clog2(BUF_BYTES + 1),
    localparam int unsigned CNT_W = $clog2(BUF_COUNT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic [CNT_W-1:0] cnt_next,
    output logic             accept,
    output logic             commit,
    output logic [IDX_W-1:0] wr_buf,
    output logic [OFF_W-1:0] wr_off,
    output logic [LEN_W-1:0] commit_len,
    output logic             nak
);
    prod_state_e state_q;
    prod_state_e state_d;
    logic        at_end;
    logic        full_next;

    assign at_end    = (wr_off == OFF_W'(BUF_BYTES - 1));
    assign full_next = (cnt_next == CNT_W'(BUF_COUNT));

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= P_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            P_OPEN: begin
                if (full_next)               state_d = P_FULL;
                else if (accept && !commit)  state_d = P_FILL;
            end
            P_FILL: begin
                if (full_next)               state_d = P_FULL;
                else if (commit)             state_d = P_OPEN;
            end
            P_FULL: begin
                if (!full_next)              state_d = P_OPEN;
            end
            default:                         state_d = P_OPEN;
        endcase
    end

    // outputs
    always_comb begin
        nak        = (state_q == P_FULL);
        accept     = in_valid && (state_q != P_FULL);
        commit     = accept && (in_last || at_end);
        commit_len = LEN_W'(wr_off) + LEN_W'(1);
    end

    // write pointer
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_buf <= '0;
            wr_off <= '0;
        end else if (commit) begin
            wr_off <= '0;
            wr_buf <= (wr_buf == IDX_W'(BUF_COUNT - 1)) ? '0 : wr_buf + IDX_W'(1);
        end else if (accept) begin
            wr_off <= wr_off + OFF_W'(1);
        end
    end

    // R6
    full_no_partial_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == P_FULL) |-> (wr_off == '0));
endmodule

// File: rtl/mbf_cons_ctl.sv
module mbf_cons_ctl import mbf_pkg::*; #(
    parameter int unsigned BUF_BYTES = 16,
    parameter int unsigned BUF_COUNT = 4,
    localparam int unsigned IDX_W = idx_width(BUF_COUNT),
    localparam int unsigned OFF_W = idx_width(BUF_BYTES),
    localparam int unsigned LEN_W = $clog2(BUF_BYTES + 1),
    localparam int unsigned CNT_W = $clog2(BUF_COUNT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             out_ready,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic [LEN_W-1:0] rd_len,
    output logic             out_valid,
    output logic             out_eob,
    output logic             release_buf,
    output logic [IDX_W-1:0] rd_buf,
    output logic [OFF_W-1:0] rd_off
);
    cons_state_e state_q;
    cons_state_e state_d;
    logic        last_byte;
    logic        fire;

    assign last_byte = ((LEN_W'(rd_off) + LEN_W'(1)) == rd_len);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= C_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_IDLE:  if (cnt_next != '0) state_d = C_DRAIN;
            C_DRAIN: if (cnt_next == '0) state_d = C_IDLE;
            default: state_d = C_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        out_valid   = (state_q == C_DRAIN);
        fire        = out_valid && out_ready;
        out_eob     = out_valid && last_byte;
        release_buf = fire && last_byte;
    end

    // read pointer
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_buf <= '0;
            rd_off <= '0;
        end else if (fire) begin
            if (last_byte) begin
                rd_off <= '0;
                rd_buf <= (rd_buf == IDX_W'(BUF_COUNT - 1)) ? '0 : rd_buf + IDX_W'(1);
            end else begin
                rd_off <= rd_off + OFF_W'(1);
            end
        end
    end

    // R10
    hold_when_stalled_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(rd_off) && $stable(rd_buf)));

    // R4
    offset_in_length_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (LEN_W'(rd_off) < rd_len));
endmodule

// File: rtl/mbf_thread_flag.sv
module mbf_thread_flag import mbf_pkg::*; #(
    parameter int unsigned NUM_THR = 4,
    parameter int unsigned BACKED  = 1,
    localparam int unsigned SEL_W = idx_width(NUM_THR)
) (
    input  logic [SEL_W-1:0]  thr_sel,
    input  logic [BACKED-1:0] backed_empty,
    output logic              sel_empty
);
    logic [NUM_THR-1:0] empties;

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        if (t < BACKED) begin : g_backed
            assign empties[t] = backed_empty[t];
        end else begin : g_unbacked
            assign empties[t] = 1'b1;
        end
    end

    assign sel_empty = empties[thr_sel];
endmodule

// File: rtl/mbf_commit_fifo.sv
module mbf_commit_fifo import mbf_pkg::*; #(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned BUF_BYTES = 16,
    parameter int unsigned BUF_COUNT = 4,
    parameter int unsigned NUM_THR   = 4,
    localparam int unsigned THR_W = idx_width(NUM_THR)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prod_valid,
    input  logic [DATA_W-1:0] prod_data,
    input  logic              prod_last,
    output logic              prod_nak,
    input  logic              cons_ready,
    output logic              cons_valid,
    output logic [DATA_W-1:0] cons_data,
    output logic              cons_eob,
    input  logic [THR_W-1:0]  thr_addr,
    output logic              thr_empty
);
    localparam int unsigned IDX_W = idx_width(BUF_COUNT);
    localparam int unsigned OFF_W = idx_width(BUF_BYTES);
    localparam int unsigned LEN_W = $clog2(BUF_BYTES + 1);
    localparam int unsigned CNT_W = $clog2(BUF_COUNT + 1);

    logic             accept;
    logic             commit;
    logic             release_buf;
    logic [IDX_W-1:0] wr_buf;
    logic [OFF_W-1:0] wr_off;
    logic [LEN_W-1:0] commit_len;
    logic [IDX_W-1:0] rd_buf;
    logic [OFF_W-1:0] rd_off;
    logic [LEN_W-1:0] rd_len;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // committed-but-unreleased buffer count
    assign cnt_d = cnt_q + CNT_W'(commit) - CNT_W'(release_buf);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    mbf_prod_ctl #(.BUF_BYTES(BUF_BYTES), .BUF_COUNT(BUF_COUNT)) u_prod (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (prod_valid),
        .in_last    (prod_last),
        .cnt_next   (cnt_d),
        .accept     (accept),
        .commit     (commit),
        .wr_buf     (wr_buf),
        .wr_off     (wr_off),
        .commit_len (commit_len),
        .nak        (prod_nak)
    );

    mbf_store #(.DATA_W(DATA_W), .BUF_BYTES(BUF_BYTES), .BUF_COUNT(BUF_COUNT)) u_store (
        .clk     (clk),
        .wr_en   (accept),
        .wr_buf  (wr_buf),
        .wr_off  (wr_off),
        .wr_data (prod_data),
        .len_we  (commit),
        .len_val (commit_len),
        .rd_buf  (rd_buf),
        .rd_off  (rd_off),
        .rd_data (cons_data),
        .rd_len  (rd_len)
    );

    mbf_cons_ctl #(.BUF_BYTES(BUF_BYTES), .BUF_COUNT(BUF_COUNT)) u_cons (
        .clk         (clk),
        .rst         (rst),
        .out_ready   (cons_ready),
        .cnt_next    (cnt_d),
        .rd_len      (rd_len),
        .out_valid   (cons_valid),
        .out_eob     (cons_eob),
        .release_buf (release_buf),
        .rd_buf      (rd_buf),
        .rd_off      (rd_off)
    );

    mbf_thread_flag #(.NUM_THR(NUM_THR), .BACKED(1)) u_flag (
        .thr_sel      (thr_addr),
        .backed_empty (!cons_valid),
        .sel_empty    (thr_empty)
    );

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(BUF_COUNT));

    // R6
    nak_matches_count_chk: assert property (@(posedge clk) disable iff (rst)
        prod_nak == (cnt_q == CNT_W'(BUF_COUNT)));

    // R8
    empty_follows_count_chk: assert property (@(posedge clk) disable iff (rst)
        (thr_addr == '0) |-> (thr_empty == (cnt_q == '0)));

    // R7
    release_frees_chk: assert property (@(posedge clk) disable iff (rst)
        (cons_valid && cons_ready && cons_eob && !commit) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: tb/mbf_commit_fifo_test.sv
module mbf_commit_fifo_test;
    localparam int BB = 4;
    localparam int BC = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prod_valid = 1'b0;
    logic [7:0] prod_data = 8'd0;
    logic       prod_last = 1'b0;
    logic       cons_ready = 1'b0;
    logic [1:0] thr_addr = 2'd0;
    logic       prod_nak;
    logic       cons_valid;
    logic [7:0] cons_data;
    logic       cons_eob;
    logic       thr_empty;

    int         checks = 0;
    int         errors = 0;
    int         mcnt = 0;
    int         overlap = 0;
    bit         done = 1'b0;
    string      dtag = "R2";
    logic [8:0] commit_q[$];
    logic [8:0] part_q[$];

    always #10 clk = ~clk;   // 20 ns period, 50 MHz

    mbf_commit_fifo #(.DATA_W(8), .BUF_BYTES(BB), .BUF_COUNT(BC), .NUM_THR(4)) uut (
        .clk        (clk),
        .rst        (rst),
        .prod_valid (prod_valid),
        .prod_data  (prod_data),
        .prod_last  (prod_last),
        .prod_nak   (prod_nak),
        .cons_ready (cons_ready),
        .cons_valid (cons_valid),
        .cons_data  (cons_data),
        .cons_eob   (cons_eob),
        .thr_addr   (thr_addr),
        .thr_empty  (thr_empty)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one clock cycle: check outputs against the model, drive, update model
    task automatic step(input bit pv, input logic [7:0] pd, input bit pl,
                        input bit cr, input logic [1:0] ta);
        bit         full;
        bit         acc;
        bit         fire;
        logic [8:0] e;
        @(negedge clk);
        thr_addr = ta;
        #1;
        full = (mcnt == BC);
        chk("R6 nak", int'(prod_nak), int'(full));
        chk("R3 valid", int'(cons_valid), int'(mcnt != 0));
        chk("R8 empty", int'(thr_empty), int'((ta != 2'd0) || (mcnt == 0)));
        if (mcnt != 0) begin
            chk({dtag, " data"}, int'(cons_data), int'(commit_q[0][7:0]));
            chk("R4 eob", int'(cons_eob), int'(commit_q[0][8]));
        end
        prod_valid = pv;
        prod_data  = pd;
        prod_last  = pl;
        cons_ready = cr;
        acc  = pv && !full;
        fire = cr && (mcnt != 0);
        if (acc && fire) overlap++;
        @(posedge clk);
        if (fire) begin
            e = commit_q.pop_front();
            if (e[8]) mcnt--;
        end
        if (acc) begin
            part_q.push_back({1'b0, pd});
            if (pl || (part_q.size() == BB)) begin
                part_q[part_q.size() - 1][8] = 1'b1;
                foreach (part_q[k]) commit_q.push_back(part_q[k]);
                part_q.delete();
                mcnt++;
            end
        end
        #1;
        prod_valid = 1'b0;
        prod_last  = 1'b0;
        cons_ready = 1'b0;
    endtask

    task automatic drain();
        while (mcnt != 0) step(1'b0, 8'd0, 1'b0, 1'b1, 2'd0);
        step(1'b0, 8'd0, 1'b0, 1'b0, 2'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1 valid", int'(cons_valid), 0);
        chk("R1 nak", int'(prod_nak), 0);
        chk("R1 empty", int'(thr_empty), 1);

        // R4 / R2: sweep packet lengths 1 .. 2*BB+1, each ended by prod_last
        dtag = "R2";
        for (int len = 1; len <= 2 * BB + 1; len++) begin
            for (int i = 0; i < len; i++) begin
                step(1'b1, 8'(len * 16 + i), (i == len - 1), 1'b0, 2'd0);
            end
            drain();
        end

        // R3: a stream without prod_last commits on full buffers only
        for (int i = 0; i < 2 * BB; i++) step(1'b1, 8'(8'hA0 + i), 1'b0, 1'b0, 2'd0);
        chk("R3 full commits", mcnt, 2);
        drain();

        // R6 / R7: fill the ring, offer bytes while refused, then free one buffer
        dtag = "R6";
        for (int i = 0; i < BC; i++) step(1'b1, 8'(8'h40 + i), 1'b1, 1'b0, 2'd0);
        for (int i = 0; i < 3; i++) step(1'b1, 8'hEE, 1'b0, 1'b0, 2'd0);
        step(1'b0, 8'd0, 1'b0, 1'b1, 2'd0);
        @(negedge clk);
        #1;
        chk("R7 nak after release", int'(prod_nak), 0);
        step(1'b1, 8'h55, 1'b1, 1'b0, 2'd0);
        drain();

        // R10: stalled consumer keeps its byte
        dtag = "R10";
        step(1'b1, 8'h30, 1'b0, 1'b0, 2'd0);
        step(1'b1, 8'h31, 1'b1, 1'b0, 2'd0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            #1;
            chk("R10 valid held", int'(cons_valid), 1);
            chk("R10 data held", int'(cons_data), 8'h30);
            chk("R10 eob held", int'(cons_eob), 0);
        end
        drain();

        // R9 / R5: both sides active, thread address swept
        dtag = "R5";
        for (int i = 0; i < 120; i++) begin
            step((i % 3) != 2, 8'(i), (i % 7) == 6, (i % 4) != 3, 2'(i % 4));
        end
        while (part_q.size() != 0) step(1'b1, 8'hAA, 1'b1, 1'b1, 2'd1);
        drain();
        chk("R9 overlap seen", int'(overlap > 0), 1);

        // R1: reset in the middle of traffic
        step(1'b1, 8'h11, 1'b1, 1'b0, 2'd0);
        step(1'b1, 8'h12, 1'b0, 1'b0, 2'd0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        commit_q.delete();
        part_q.delete();
        mcnt = 0;
        #1;
        chk("R1 valid after reset", int'(cons_valid), 0);
        chk("R1 empty after reset", int'(thr_empty), 1);
        chk("R1 nak after reset", int'(prod_nak), 0);
        dtag = "R2";
        step(1'b1, 8'h77, 1'b1, 1'b0, 2'd0);
        drain();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (R1..R10 run): actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule